// File: doc/BRIEF.md
# Capture/Compare Timer with Overflow Flag

An up-counter that advances by one on each count-enable pulse while the timer runs. A start/stop input gates all activity. The counter has three clearing behaviours. In free-running mode it only wraps. In match-clear mode it returns to zero after the count equal to the channel-0 register. In edge-clear mode it returns to zero on a valid edge of external input 0.

Channel 0 and channel 1 each hold one register. Each register works either as a compare value or as a capture target. Channel 0 captures the count on a valid edge of input 1. Channel 1 captures the count on a valid edge of input 0. Both external inputs pass through a two-flop synchronizer. Each input has its own choice of rising, falling or both edges as its valid edge.

A small register port gives software access to the counter, the two channel registers and a status word. Through it, software reads the counter, reads or writes either channel register, and clears the overflow flag. The flag is set when a count step takes the counter from the all-ones value to zero. Software cannot clear the flag while the counter still holds zero after that wrap. The match pulse lasts one cycle, and it marks a count step taken while the counter equals the channel-0 compare value.

Top module: `cc_timer`

## Requirements
- R1: After reset the counter, both channel registers, the overflow flag and `match_irq` are all 0.
- R2: While `run`=1, each cycle with `cnt_en`=1 adds one to the counter. A cycle with `cnt_en`=0 leaves the counter unchanged.
- R3: With `mode`=2'b01 and channel 0 in compare mode, a count step taken while the counter equals channel 0 loads 0 into the counter. The same step raises `match_irq` for exactly the following cycle. With channel 0 at FFFFh the counter reads FFFEh, FFFFh, 0000h, 0001h on successive steps.
- R4: With `mode`=2'b00, a step from FFFFh gives 0000h and sets the overflow flag.
- R5: Any count step from FFFFh sets the flag. The flag is status bit 0, at `cpu_addr`=3. Writing 0 to that bit clears the flag, and writing 1 leaves it unchanged.
- R6: A software clear of the flag is ignored while the counter still holds the 0000h reached by the wrap, that is, before the next count step.
- R7: With `mode`=2'b10, a valid edge on `ti0` loads 0 into the counter.
- R8: Each input has its own `edge_sel` code: 2'b01 selects rising edges, 2'b10 falling, 2'b11 both, and 2'b00 none. An edge of a type the code does not select has no effect.
- R9: A register in capture mode loads the counter value on its trigger edge. Channel 0 uses `ti1` and channel 1 uses `ti0`. The captured value is the count from before any clear caused by the same edge.
- R10: A capture still loads its register when a CPU read of that register falls in the same cycle.
- R11: Reading the counter (`cpu_addr`=0) causes no capture and leaves both channel registers unchanged. Channel 0 is at `cpu_addr`=1 and channel 1 at `cpu_addr`=2.
- R12: While `run`=0, the counter holds, and edges on `ti0` and `ti1` cause no capture, clear or flag change, including after `run` returns to 1.
- R13: While channel 0 is in capture mode (`ch0_cap`=1), `match_irq` stays 0 and no match clear occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | 1 = timer running, 0 = stopped |
| cnt_en | input | 1 | Count-enable pulse (one step per cycle high) |
| mode | input | 2 | 00 free-running, 01 clear on channel-0 match, 10 clear on ti0 edge |
| ch0_cap | input | 1 | Channel 0: 1 = capture, 0 = compare |
| ch1_cap | input | 1 | Channel 1: 1 = capture, 0 = compare |
| edge_sel0 | input | 2 | Valid-edge code for ti0 |
| edge_sel1 | input | 2 | Valid-edge code for ti1 |
| ti0 | input | 1 | External input 0 (asynchronous) |
| ti1 | input | 1 | External input 1 (asynchronous) |
| cpu_addr | input | 2 | 0 counter, 1 channel 0, 2 channel 1, 3 status |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe; data valid the cycle after |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Registered read data |
| ovf_flag | output | 1 | Overflow flag |
| match_irq | output | 1 | One-cycle match pulse |

## Verification
Counting is tried in three ways. A vector table sets mode and compare value, applies isolated pulses and compares both the final count and the number of match pulses. This separates free-running from match-clear behaviour and covers a compare value of zero. A continuous pulse run walks the counter through FFFEh to 0001h, and through the free-running wrap, to show when the flag can be set and cleared. Edge tests flip each input in both directions under every edge code, with counting paused, so a clear or a capture can only come from the edge.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  typedef enum logic [1:0] {
    CCT_FREE   = 2'b00,
    CCT_MATCH  = 2'b01,
    CCT_EXTCLR = 2'b10
  } cct_mode_e;

  localparam logic [1:0] ADR_CNT  = 2'd0;
  localparam logic [1:0] ADR_CH0  = 2'd1;
  localparam logic [1:0] ADR_CH1  = 2'd2;
  localparam logic [1:0] ADR_STAT = 2'd3;

  // valid-edge decision: sel[0] rising, sel[1] falling
  function automatic logic edge_hit(input logic [1:0] sel, input logic prev, input logic cur);
    return (sel[0] & ~prev & cur) | (sel[1] & prev & ~cur);
  endfunction

  // next counter value for one count step
  function automatic logic [15:0] step_val(input logic [15:0] cnt, input logic clr);
    return clr ? 16'h0000 : cnt + 16'h0001;
  endfunction
endpackage

// File: rtl/cct_edge.sv
module cct_edge
  import cc_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       hit
);
  logic s1, s2, prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; prev <= 1'b0;
    end else begin
      s1 <= pin; s2 <= s1; prev <= s2;
    end
  end

  assign hit = edge_hit(sel, prev, s2);
endmodule

// File: rtl/cct_ccreg.sv
module cct_ccreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_ev,
  input  logic [W-1:0] cnt_in,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (cap_ev) q <= cnt_in;   // capture wins over CPU access
    else if (wr_en)  q <= wdata;
  end

  assert_capture_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> q == $past(cnt_in));
endmodule

// File: rtl/cct_counter.sv
module cct_counter
  import cc_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [1:0]   mode,
  input  logic         cmp_en,
  input  logic [W-1:0] cmp_val,
  input  logic         ext_clr,
  input  logic         sw_clr,
  output logic [W-1:0] cnt,
  output logic         ovf_flag,
  output logic         match_irq,
  output logic         cmp_hit,
  output logic         wrap_ev
);
  localparam logic [W-1:0] ALL_ONES = '1;
  logic match_clr, wrap_hold;

  assign cmp_hit   = step & cmp_en & (cnt == cmp_val);
  assign match_clr = cmp_hit & (mode == CCT_MATCH);
  assign wrap_ev   = step & (cnt == ALL_ONES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; ovf_flag <= 1'b0; match_irq <= 1'b0; wrap_hold <= 1'b0;
    end else begin
      if (ext_clr)   cnt <= '0;
      else if (step) cnt <= W'(step_val(16'(cnt), match_clr));
      match_irq <= cmp_hit;
      if (wrap_ev)   wrap_hold <= 1'b1;
      else if (step || ext_clr) wrap_hold <= 1'b0;
      ovf_flag  <= wrap_ev | (ovf_flag & ~(sw_clr & ~wrap_hold));
    end
  end

  assert_hold_stopped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ext_clr && !match_clr) |=> cnt == W'($past(cnt) + 1'b1));
  assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> ovf_flag);
  assert_irq_source_R13: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> $past(cmp_en));
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cnt_en,
  input  logic [1:0]   mode,
  input  logic         ch0_cap,
  input  logic         ch1_cap,
  input  logic [1:0]   edge_sel0,
  input  logic [1:0]   edge_sel1,
  input  logic         ti0,
  input  logic         ti1,
  input  logic [1:0]   cpu_addr,
  input  logic         cpu_wr,
  input  logic         cpu_rd,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  output logic         ovf_flag,
  output logic         match_irq
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_ev, run_ev, cap_mode, cap_ev, wr_ch;
  logic [W-1:0]   ch_q [NCH];
  logic [W-1:0]   cnt;
  logic           ext_clr, sw_clr, step, cmp_hit, wrap_ev;

  cct_edge u_e0 (.clk(clk), .rst_n(rst_n), .pin(ti0), .sel(edge_sel0), .hit(raw_ev[0]));
  cct_edge u_e1 (.clk(clk), .rst_n(rst_n), .pin(ti1), .sel(edge_sel1), .hit(raw_ev[1]));

  assign run_ev   = raw_ev & {NCH{run}};
  assign cap_mode = {ch1_cap, ch0_cap};
  assign step     = run & cnt_en;
  assign ext_clr  = run_ev[0] & (mode == CCT_EXTCLR);
  assign sw_clr   = cpu_wr & (cpu_addr == ADR_STAT) & ~cpu_wdata[0];

  // channel k is triggered by the opposite input
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign cap_ev[k] = cap_mode[k] & run_ev[NCH-1-k];
    assign wr_ch[k]  = cpu_wr & (cpu_addr == 2'(k + 1));
    cct_ccreg #(.W(W)) u_reg (
      .clk(clk), .rst_n(rst_n), .cap_ev(cap_ev[k]), .cnt_in(cnt),
      .wr_en(wr_ch[k]), .wdata(cpu_wdata), .q(ch_q[k]));
  end

  cct_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step), .mode(mode),
    .cmp_en(~ch0_cap), .cmp_val(ch_q[0]), .ext_clr(ext_clr), .sw_clr(sw_clr),
    .cnt(cnt), .ovf_flag(ovf_flag), .match_irq(match_irq),
    .cmp_hit(cmp_hit), .wrap_ev(wrap_ev));

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_rdata <= '0;
    else if (cpu_rd) begin
      unique case (cpu_addr)
        ADR_CNT:  cpu_rdata <= cnt;
        ADR_CH0:  cpu_rdata <= ch_q[0];
        ADR_CH1:  cpu_rdata <= ch_q[1];
        default:  cpu_rdata <= {{(W-1){1'b0}}, ovf_flag};
      endcase
    end
  end

  assert_no_cap_stopped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(ch_q[0]) || $past(wr_ch[0])) && ($stable(ch_q[1]) || $past(wr_ch[1])));
  assert_no_match_capture_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ch0_cap |-> !cmp_hit);
  assert_wrap_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && !ext_clr) |=> cnt == '0);
endmodule

// File: tb/tb_cc_timer.sv
module tb_cc_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic clk = 0, rst_n = 0, run = 1, cnt_en = 0, ch0_cap = 0, ch1_cap = 0;
  logic ti0 = 0, ti1 = 0, cpu_wr = 0, cpu_rd = 0;
  logic [1:0] mode = 0, edge_sel0 = 2'b01, edge_sel1 = 2'b01, cpu_addr = 0;
  logic [15:0] cpu_wdata = 0, cpu_rdata, rv;
  logic ovf_flag, match_irq;
  int checks = 0, fails = 0, nirq;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_timer dut (.*);

  typedef struct packed {
    logic [1:0] mode; logic [15:0] cr0; logic [7:0] pulses;
    logic [15:0] cnt; logic [7:0] irqs;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{2'b00, 16'hFFFF, 8'd10, 16'd10, 8'd0},
    '{2'b01, 16'd3,    8'd10, 16'd2,  8'd2},
    '{2'b01, 16'd0,    8'd4,  16'd0,  8'd4},
    '{2'b00, 16'd2,    8'd6,  16'd6,  8'd1},
    '{2'b01, 16'd5,    8'd5,  16'd5,  8'd0}};

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk) begin cpu_addr = a; cpu_rd = 1; end
    @(negedge clk) begin cpu_rd = 0; d = cpu_rdata; end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk) begin cpu_addr = a; cpu_wdata = d; cpu_wr = 1; end
    @(negedge clk) cpu_wr = 0;
  endtask

  // isolated pulses, counting match pulses
  task automatic pulses(int n);
    nirq = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cnt_en = 1;
      @(negedge clk) begin if (match_irq) nirq++; cnt_en = 0; end
    end
    @(negedge clk);
  endtask

  task automatic burst(int n);
    @(negedge clk) cnt_en = 1;
    repeat (n) @(negedge clk);
    cnt_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(2'd0, rv); chk("R1 cnt", rv, 0);
    rd(2'd1, rv); chk("R1 ch0", rv, 0);
    rd(2'd2, rv); chk("R1 ch1", rv, 0);
    rd(2'd3, rv); chk("R1 flag", rv, 0);
    chk("R1 irq", 16'(match_irq), 0);

    // vector table: R2 counting, R3 match clear
    foreach (VECS[i]) begin
      mode = VECS[i].mode;
      do_reset();
      wr(2'd1, VECS[i].cr0);
      pulses(int'(VECS[i].pulses));
      rd(2'd0, rv);
      chk("R2/R3 vec count", rv, VECS[i].cnt);
      chk("R3 vec irqs", 16'(nirq), 16'(VECS[i].irqs));
    end

    // R2 hold when no pulse or stopped
    do_reset(); mode = 2'b00;
    pulses(2);
    repeat (3) @(negedge clk);
    rd(2'd0, rv); chk("R2 hold no pulse", rv, 2);
    run = 0; pulses(3); run = 1;
    rd(2'd0, rv); chk("R12 hold stopped", rv, 2);

    // R7/R9 edge clear with capture of prior count
    do_reset(); mode = 2'b10; ch1_cap = 1; edge_sel0 = 2'b01;
    pulses(5);
    @(negedge clk) ti0 = 1; settle();
    rd(2'd0, rv); chk("R7 ext clear", rv, 0);
    rd(2'd2, rv); chk("R9 ch1 capture before clear", rv, 5);

    // R8 edge codes
    pulses(3);
    @(negedge clk) ti0 = 0; settle();
    rd(2'd0, rv); chk("R8 fall ignored under rise", rv, 3);
    edge_sel0 = 2'b10;
    @(negedge clk) ti0 = 1; settle();
    rd(2'd0, rv); chk("R8 rise ignored under fall", rv, 3);
    @(negedge clk) ti0 = 0; settle();
    rd(2'd0, rv); chk("R8 fall clears", rv, 0);
    edge_sel0 = 2'b11; pulses(2);
    @(negedge clk) ti0 = 1; settle();
    rd(2'd0, rv); chk("R8 both clears", rv, 0);
    edge_sel0 = 2'b00; pulses(2);
    @(negedge clk) ti0 = 0; settle();
    rd(2'd0, rv); chk("R8 none ignored", rv, 2);

    // R11 counter read causes no capture
    wr(2'd2, 16'h1234);
    pulses(1);
    rd(2'd0, rv); chk("R11 counter read", rv, 3);
    rd(2'd2, rv); chk("R11 ch1 unchanged", rv, 16'h1234);

    // R10 capture into ch0 coinciding with its read
    ch0_cap = 1; edge_sel1 = 2'b01;
    @(negedge clk) ti1 = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) begin cpu_addr = 2'd1; cpu_rd = 1; end
    @(negedge clk) cpu_rd = 0;
    settle();
    rd(2'd1, rv); chk("R10 capture wins over read", rv, 3);

    // R12 stopped: edges ignored, also after restart
    edge_sel0 = 2'b01; run = 0;
    @(negedge clk) begin ti0 = 1; ti1 = 0; end
    edge_sel1 = 2'b11; settle(); pulses(2);
    run = 1; settle();
    rd(2'd0, rv); chk("R12 no clear when stopped", rv, 3);
    rd(2'd2, rv); chk("R12 no ch1 capture", rv, 16'h1234);
    rd(2'd1, rv); chk("R12 no ch0 capture", rv, 3);

    // R13 no match while channel 0 captures
    mode = 2'b01; pulses(1);
    chk("R13 no irq", 16'(nirq), 0);
    rd(2'd0, rv); chk("R13 no match clear", rv, 4);

    // R3/R5/R6 wrap through FFFF in match mode
    ch0_cap = 0; ch1_cap = 0; mode = 2'b00;
    do_reset();
    wr(2'd1, 16'hFFFF);
    burst(65534);
    rd(2'd0, rv); chk("R3 reach FFFE", rv, 16'hFFFE);
    mode = 2'b01;
    pulses(1);
    rd(2'd0, rv); chk("R3 FFFF", rv, 16'hFFFF);
    rd(2'd3, rv); chk("R5 flag clear before wrap", rv, 0);
    pulses(1);
    chk("R3 irq at FFFF", 16'(nirq), 1);
    rd(2'd0, rv); chk("R3 rolls to 0000", rv, 0);
    rd(2'd3, rv); chk("R5 flag set", rv, 1);
    wr(2'd3, 16'h0000);
    rd(2'd3, rv); chk("R6 clear ignored at 0000", rv, 1);
    wr(2'd3, 16'h0001);
    rd(2'd3, rv); chk("R5 write 1 no effect", rv, 1);
    pulses(1);
    rd(2'd0, rv); chk("R3 then 0001", rv, 1);
    wr(2'd3, 16'h0000);
    rd(2'd3, rv); chk("R5 clear works", rv, 0);

    // R4 free-running wrap
    mode = 2'b00;
    burst(65535);
    rd(2'd0, rv); chk("R4 wrap to 0", rv, 0);
    rd(2'd3, rv); chk("R4 flag set", rv, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule